// File: doc/BRIEF.md
# Processor Interrupt Input Controller

This block sits between the control pins of a 32-bit processor core and the core itself. It conditions seven pins of mixed polarity and sensitivity: timebase enable, external interrupt, system-management interrupt, machine check, checkstop, hard reset and soft reset. From them it produces a pending-interrupt vector with one bit per interrupt source, a combined interrupt request, a timebase run level, a core-halt flag and a single-cycle reset request.

The block keeps a registered copy of the last level seen on every pin. A pin produces an event only in a cycle where its level differs from that stored copy, so a level that is held or repeated has no effect. The core acknowledges a latched machine check through a dedicated clear input. Every output is registered and follows a pin event by one clock edge. The synchronous reset returns all state to idle, and it is the only way to release a halt caused by checkstop.

Top module: `pin_irq_ctrl`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released with all pins idle, `pend` is 0, and `irq_req`, `tb_run`, `core_halt` and `rst_req` are all 0. The idle pin levels are: interrupt, soft-reset and timebase pins low; machine-check, checkstop and hard-reset pins high.
- R2: `pend` bit 0 follows the active-high external interrupt pin. It is set or cleared at the clock edge after the pin changes.
- R3: `pend` bit 1 follows the active-high system-management interrupt pin with the same timing as R2.
- R4: A 1-to-0 transition on `pin_mchk` sets `pend` bit 2 at the next edge. A 0-to-1 transition leaves that bit unchanged.
- R5: A high `mchk_ack` clears `pend` bit 2 at the next edge. If a new falling edge arrives in the same cycle, the bit is set instead.
- R6: A low level newly seen on `pin_ckstp_n` sets `core_halt`. Raising the pin again does not clear it; only `rst` clears it.
- R7: A 1-to-0 transition on `pin_hreset_n` produces a `rst_req` pulse exactly one cycle long. Holding the pin low produces no further pulses.
- R8: `pend` bit 3 follows the active-high soft-reset pin with the same timing as R2.
- R9: `tb_run` follows the active-high timebase-enable pin one edge after it changes.
- R10: `irq_req` is high exactly when `pend` is nonzero, and it updates at the same edge as `pend`.
- R11: A pin that holds its level causes no event. For example, `pin_mchk` held low after an acknowledge does not set `pend` bit 2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_tben | input | 1 | Timebase enable, active high |
| pin_ext_irq | input | 1 | External interrupt, active high level |
| pin_smi | input | 1 | System-management interrupt, active high level |
| pin_mchk | input | 1 | Machine check, falling-edge sensitive |
| pin_ckstp_n | input | 1 | Checkstop, active low |
| pin_hreset_n | input | 1 | Hard reset, active low |
| pin_sreset | input | 1 | Soft reset interrupt, active high level |
| mchk_ack | input | 1 | Core acknowledge that clears the machine-check pending bit |
| pend | output | 4 | Pending vector: bit 0 external, bit 1 SMI, bit 2 machine check, bit 3 soft reset |
| irq_req | output | 1 | Combined interrupt request |
| tb_run | output | 1 | Timebase counters run while high |
| core_halt | output | 1 | Core halted by checkstop |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong stored pin level shows up at the ports within one edge. It appears as a missing or duplicated event: a machine-check bit that is set again while the pin is held low, or a second reset pulse while the hard-reset pin is held low. A pending bit left stale would leave `irq_req` high after every source has gone idle. An acknowledge that wins over a simultaneous edge would drop a machine check, which shows on `pend` bit 2 one edge later. A halt flag released by anything other than reset is visible on `core_halt` at the edge after the checkstop pin rises.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // pin vector layout
  localparam int NPIN    = 7;
  localparam int P_TBEN  = 0;
  localparam int P_EXT   = 1;
  localparam int P_SMI   = 2;
  localparam int P_MCHK  = 3;
  localparam int P_CKSTP = 4;
  localparam int P_HRST  = 5;
  localparam int P_SRST  = 6;

  // pending vector layout (visible at the ports)
  localparam int NSRC   = 4;
  localparam int S_EXT  = 0;
  localparam int S_SMI  = 1;
  localparam int S_MCHK = 2;
  localparam int S_SRST = 3;

  // idle levels: machine check, checkstop and hard reset rest high
  localparam logic [NPIN-1:0] PIN_IDLE = 7'b0111000;
endpackage

// File: rtl/pic_pin_track.sv
module pic_pin_track #(
  parameter int              W    = 7,
  parameter logic [W-1:0]    IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] chg
);
  logic [W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= IDLE;
    else     seen_q <= pin;
  end

  assign chg = pin ^ seen_q;

  // R11
  quiet_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chg == '0) |=> (seen_q == $past(seen_q)));
endmodule

// File: rtl/pic_pend_bank.sv
module pic_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] upd,
  input  logic [N-1:0] val,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pend_d[i] = upd[i] ? val[i] : pend[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      irq  <= |pend_d;
    end
  end

  // R10
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));

  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd == '0) |=> $stable(pend));
endmodule

// File: rtl/pic_ctl_strobes.sv
module pic_ctl_strobes (
  input  logic clk,
  input  logic rst,
  input  logic tb_chg,
  input  logic tb_lvl,
  input  logic halt_fall,
  input  logic hrst_fall,
  output logic tb_run,
  output logic core_halt,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tb_run    <= 1'b0;
      core_halt <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (tb_chg)    tb_run    <= tb_lvl;
      if (halt_fall) core_halt <= 1'b1;
      rst_req <= hrst_fall;
    end
  end

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    core_halt |=> core_halt);

  // R7
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  rst_pulse_follows_chk: assert property (@(posedge clk) disable iff (rst)
    hrst_fall |=> rst_req);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_tben,
  input  logic            pin_ext_irq,
  input  logic            pin_smi,
  input  logic            pin_mchk,
  input  logic            pin_ckstp_n,
  input  logic            pin_hreset_n,
  input  logic            pin_sreset,
  input  logic            mchk_ack,
  output logic [NSRC-1:0] pend,
  output logic            irq_req,
  output logic            tb_run,
  output logic            core_halt,
  output logic            rst_req
);
  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] chg;
  logic [NSRC-1:0] upd;
  logic [NSRC-1:0] val;
  logic            mchk_fall;

  always_comb begin
    pins          = '0;
    pins[P_TBEN]  = pin_tben;
    pins[P_EXT]   = pin_ext_irq;
    pins[P_SMI]   = pin_smi;
    pins[P_MCHK]  = pin_mchk;
    pins[P_CKSTP] = pin_ckstp_n;
    pins[P_HRST]  = pin_hreset_n;
    pins[P_SRST]  = pin_sreset;
  end

  pic_pin_track #(.W(NPIN), .IDLE(PIN_IDLE)) u_track (
    .clk (clk),
    .rst (rst),
    .pin (pins),
    .chg (chg)
  );

  assign mchk_fall = chg[P_MCHK] & ~pins[P_MCHK];

  always_comb begin
    upd         = '0;
    val         = '0;
    upd[S_EXT]  = chg[P_EXT];
    val[S_EXT]  = pins[P_EXT];
    upd[S_SMI]  = chg[P_SMI];
    val[S_SMI]  = pins[P_SMI];
    upd[S_SRST] = chg[P_SRST];
    val[S_SRST] = pins[P_SRST];
    // a new falling edge wins over a same-cycle acknowledge
    upd[S_MCHK] = mchk_fall | mchk_ack;
    val[S_MCHK] = mchk_fall;
  end

  pic_pend_bank #(.N(NSRC)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .upd  (upd),
    .val  (val),
    .pend (pend),
    .irq  (irq_req)
  );

  pic_ctl_strobes u_ctl (
    .clk       (clk),
    .rst       (rst),
    .tb_chg    (chg[P_TBEN]),
    .tb_lvl    (pins[P_TBEN]),
    .halt_fall (chg[P_CKSTP] & ~pins[P_CKSTP]),
    .hrst_fall (chg[P_HRST] & ~pins[P_HRST]),
    .tb_run    (tb_run),
    .core_halt (core_halt),
    .rst_req   (rst_req)
  );

  // R4
  mchk_edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    mchk_fall |=> pend[S_MCHK]);

  // R4
  mchk_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend[S_MCHK] && !mchk_fall) |=> !pend[S_MCHK]);

  // R5
  mchk_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (mchk_ack && !mchk_fall) |=> !pend[S_MCHK]);
endmodule

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_tben = 1'b0, pin_ext_irq = 1'b0, pin_smi = 1'b0, pin_mchk = 1'b1;
  logic pin_ckstp_n = 1'b1, pin_hreset_n = 1'b1, pin_sreset = 1'b0, mchk_ack = 1'b0;
  logic [3:0] pend;
  logic irq_req, tb_run, core_halt, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst(rst), .pin_tben(pin_tben), .pin_ext_irq(pin_ext_irq),
    .pin_smi(pin_smi), .pin_mchk(pin_mchk), .pin_ckstp_n(pin_ckstp_n),
    .pin_hreset_n(pin_hreset_n), .pin_sreset(pin_sreset), .mchk_ack(mchk_ack),
    .pend(pend), .irq_req(irq_req), .tb_run(tb_run), .core_halt(core_halt),
    .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1 pend in reset", 8'(pend), 8'h0);
    rst = 1'b0;
    step();
    chk("R1 pend", 8'(pend), 8'h0);
    chk("R1 irq_req", 8'(irq_req), 8'h0);
    chk("R1 tb_run", 8'(tb_run), 8'h0);
    chk("R1 core_halt", 8'(core_halt), 8'h0);
    chk("R1 rst_req", 8'(rst_req), 8'h0);
  endtask

  task automatic t_ext_smi();
    pin_ext_irq = 1'b1; step();
    chk("R2 ext set", 8'(pend), 8'h1);
    chk("R10 irq on ext", 8'(irq_req), 8'h1);
    pin_smi = 1'b1; step();
    chk("R3 smi set", 8'(pend), 8'h3);
    pin_ext_irq = 1'b0; step();
    chk("R2 ext clear", 8'(pend), 8'h2);
    chk("R10 irq stays", 8'(irq_req), 8'h1);
    pin_smi = 1'b0; step();
    chk("R3 smi clear", 8'(pend), 8'h0);
    chk("R10 irq drops", 8'(irq_req), 8'h0);
  endtask

  task automatic t_mchk();
    pin_mchk = 1'b0; step();
    chk("R4 fall sets", 8'(pend), 8'h4);
    chk("R10 irq on mchk", 8'(irq_req), 8'h1);
    pin_mchk = 1'b1; step();
    chk("R4 rise no effect", 8'(pend), 8'h4);
    mchk_ack = 1'b1; step(); mchk_ack = 1'b0;
    chk("R5 ack clears", 8'(pend), 8'h0);
    pin_mchk = 1'b0; step();
    pin_mchk = 1'b1; step();
    pin_mchk = 1'b0; mchk_ack = 1'b1; step(); mchk_ack = 1'b0;
    chk("R5 edge beats ack", 8'(pend), 8'h4);
    mchk_ack = 1'b1; step(); mchk_ack = 1'b0;
    chk("R5 ack clears again", 8'(pend), 8'h0);
    repeat (3) step();
    chk("R11 held low no reset of bit", 8'(pend), 8'h0);
    chk("R11 irq quiet", 8'(irq_req), 8'h0);
    pin_mchk = 1'b1; step();
    chk("R4 rise after hold", 8'(pend), 8'h0);
  endtask

  task automatic t_srst_tben();
    pin_sreset = 1'b1; step();
    chk("R8 sreset set", 8'(pend), 8'h8);
    pin_sreset = 1'b0; step();
    chk("R8 sreset clear", 8'(pend), 8'h0);
    pin_tben = 1'b1; step();
    chk("R9 tb start", 8'(tb_run), 8'h1);
    step();
    chk("R9 tb held", 8'(tb_run), 8'h1);
    pin_tben = 1'b0; step();
    chk("R9 tb freeze", 8'(tb_run), 8'h0);
  endtask

  task automatic t_hreset();
    pin_hreset_n = 1'b0; step();
    chk("R7 pulse", 8'(rst_req), 8'h1);
    step();
    chk("R7 pulse ends", 8'(rst_req), 8'h0);
    step();
    chk("R7 held low no pulse", 8'(rst_req), 8'h0);
    pin_hreset_n = 1'b1; step();
    chk("R7 release no pulse", 8'(rst_req), 8'h0);
  endtask

  task automatic t_ckstp();
    pin_ext_irq = 1'b1;
    pin_ckstp_n = 1'b0; step();
    chk("R6 halt", 8'(core_halt), 8'h1);
    pin_ckstp_n = 1'b1; step();
    chk("R6 rise keeps halt", 8'(core_halt), 8'h1);
    step();
    chk("R6 still halted", 8'(core_halt), 8'h1);
    pin_ext_irq = 1'b0;
    rst = 1'b1; step(); rst = 1'b0;
    chk("R6 reset clears halt", 8'(core_halt), 8'h0);
    chk("R1 reset clears pend", 8'(pend), 8'h0);
    step();
    chk("R6 stays released", 8'(core_halt), 8'h0);
  endtask

  initial begin
    t_reset();
    t_ext_smi();
    t_mchk();
    t_srst_tben();
    t_hreset();
    t_ckstp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule